// File: doc/BRIEF.md
# Configurable Mono Audio Serial Port

This block moves one 16-bit audio sample in each direction per frame over a
four-wire serial link: a bit clock, a word clock, a data-out line and a data-in
line. Capture samples arrive from the internal data path as parallel words and
leave on the data-out line. Playback bits come in on the data-in line and are
delivered to the data path as parallel words with a one-cycle valid strobe.

One shifting engine serves every format. The port can generate both serial
clocks itself (master) from a clock-enable tick, or follow clocks supplied by
another device (slave). Static control inputs choose the frame shape, the word
clock level that marks the first slot, whether data starts one bit after the
word clock edge or right at it, and whether a slot is sent MSB or LSB first. The
single mono sample always occupies the first slot. The control inputs are
expected to change only while the port is held in reset.

In slave mode the external clocks and data-in are resynchronised to the system
clock, so each bit-clock half period must last at least four system clocks.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is asserted the data-out line is low, the driven bit clock is low, the driven word clock sits at its inactive level (the inverse of the polarity select in master mode, low in slave mode) and the receive strobe is low.
- R2: In master mode the bit clock toggles on every cycle where the clock-enable tick is high, so one bit period spans two ticks, and a frame lasts 32 bit periods when the ratio select is 0 or 64 when it is 1.
- R3: The word clock level that marks the first slot equals the polarity select (1 means high marks it). With the frame-sync select at 0 the word clock holds that level for the first half of the frame; with it at 1 it holds that level for exactly the first bit period of the frame, and the other level at all other times.
- R4: The word clock and the data-out line change only just after a falling edge of the bit clock; data-in is captured on the rising edge.
- R5: With the delay select at 1 the first data bit occupies the second bit period of the frame (position 1); with it at 0 it occupies position 0. Data bit k sits at position k plus the delay.
- R6: With the order select at 0 the slot starts with bit 15 of the sample; with it at 1 it starts with bit 0.
- R7: Bit periods outside the 16 data positions send 0 on data-out, and whatever data-in carries in them leaves the received word unchanged.
- R8: The transmit-take strobe pulses for one cycle at the falling edge that opens position 0 of each frame, and the sample present on the transmit input in that cycle is the one sent in that frame.
- R9: After the 16th data bit of a frame has been captured, the receive strobe pulses for one cycle with the assembled 16-bit word on the receive output.
- R10: In slave mode the driven bit clock and word clock outputs stay low and the clock-drive flag is low; a frame starts at a bit-clock falling edge where the incoming word clock has just reached its first-slot level, frames of any length up to 128 bit periods are followed, and the data formats of R3 to R9 apply unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | Master-mode tick; bit clock toggles on each tick |
| cfg_master | input | 1 | 1 = port drives the serial clocks, 0 = follows them |
| cfg_ratio64 | input | 1 | Master frame length: 0 = 32, 1 = 64 bit periods |
| cfg_fsync | input | 1 | 0 = half-frame word clock, 1 = one-bit sync pulse |
| cfg_pol | input | 1 | Word clock level that marks the first slot |
| cfg_delay1 | input | 1 | 1 = data starts one bit after the word clock edge |
| cfg_lsb | input | 1 | 1 = LSB first, 0 = MSB first |
| bclk_in | input | 1 | Bit clock from the external master (slave mode) |
| wclk_in | input | 1 | Word clock from the external master (slave mode) |
| sdin | input | 1 | Serial data in |
| bclk_o | output | 1 | Bit clock driven in master mode |
| wclk_o | output | 1 | Word clock driven in master mode |
| clk_drive | output | 1 | High when the port drives the serial clocks |
| sdout | output | 1 | Serial data out |
| tx_data | input | 16 | Capture sample to send |
| tx_take | output | 1 | One-cycle strobe: tx_data taken for this frame |
| rx_data | output | 16 | Received playback sample |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new sample |

## Verification
The bench plays the opposite end of the link in each mode and predicts every bit period from its own position counter. It targets delay 0 against delay 1 at position 0, where an off-by-one engine would shift the whole word by a bit and lose the LSB or MSB, and LSB-first order, where a reversed index would return a mirrored word. Junk ones are driven on data-in outside the data positions, so a receiver that did not bound its window would corrupt the word, and the sync pulse is checked for width, since a pulse held for a half frame or for none would shift the slave's frame start. Slave runs use 32-, 48-, 64- and 128-bit frames, so a counter that wrapped or a frame start taken from the wrong word clock edge shows up as misplaced data.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mclk_en,
  input  logic         cfg_master,
  input  logic         cfg_ratio64,
  input  logic         cfg_fsync,
  input  logic         cfg_pol,
  input  logic         cfg_delay1,
  input  logic         cfg_lsb,
  input  logic         bclk_in,
  input  logic         wclk_in,
  input  logic         sdin,
  output logic         bclk_o,
  output logic         wclk_o,
  output logic         clk_drive,
  output logic         sdout,
  input  logic [W-1:0] tx_data,
  output logic         tx_take,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  localparam int IW = $clog2(W);

  logic [2:0]    bsync;
  logic [1:0]    wsync, dsync;
  logic          bclk_q, first_q, act_prev;
  logic [CW-1:0] cnt;
  logic [W-1:0]  hold, acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bsync <= '0;
      wsync <= '0;
      dsync <= '0;
    end else begin
      bsync <= {bsync[1:0], bclk_in};
      wsync <= {wsync[0], wclk_in};
      dsync <= {dsync[0], sdin};
    end

  function automatic logic [IW-1:0] bpos(input logic [IW-1:0] i, input logic lsb);
    return lsb ? i : IW'(W - 1) - i;
  endfunction

  wire m_rise = cfg_master & mclk_en & ~bclk_q;
  wire m_fall = cfg_master & mclk_en & bclk_q;
  wire s_rise = ~cfg_master & bsync[1] & ~bsync[2];
  wire s_fall = ~cfg_master & ~bsync[1] & bsync[2];
  wire rise   = m_rise | s_rise;
  wire fall   = m_fall | s_fall;
  wire din    = cfg_master ? sdin : dsync[1];

  wire [CW-1:0] flen  = cfg_ratio64 ? CW'(4 * W) : CW'(2 * W);
  wire [CW-1:0] dly   = {{(CW-1){1'b0}}, cfg_delay1};
  wire [CW-1:0] m_nxt = (cnt == flen - CW'(1)) ? '0 : cnt + CW'(1);
  wire          s_act = (wsync[1] == cfg_pol);
  wire          s_beg = s_act & ~act_prev;
  wire [CW-1:0] s_nxt = s_beg ? '0 : ((&cnt) ? cnt : cnt + CW'(1));
  wire [CW-1:0] nxt   = cfg_master ? m_nxt : s_nxt;
  wire          start = (nxt == '0);

  wire [CW-1:0] t_off = nxt - dly;
  wire          t_in  = (nxt >= dly) && (t_off < CW'(W));
  wire [W-1:0]  t_wd  = start ? tx_data : hold;
  wire          t_bit = t_in & t_wd[bpos(t_off[IW-1:0], cfg_lsb)];
  wire          t_1st = cfg_fsync ? start : (nxt < (flen >> 1));

  wire [CW-1:0] r_off  = cnt - dly;
  wire          r_in   = (cnt >= dly) && (r_off < CW'(W));
  wire          r_last = (r_off == CW'(W - 1));
  logic [W-1:0] acc_n;

  always_comb begin
    acc_n = acc;
    acc_n[bpos(r_off[IW-1:0], cfg_lsb)] = din;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      cnt      <= '1;
      first_q  <= 1'b0;
      act_prev <= 1'b0;
      hold     <= '0;
      tx_take  <= 1'b0;
      sdout    <= 1'b0;
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      tx_take  <= 1'b0;
      rx_valid <= 1'b0;
      if (cfg_master && mclk_en) bclk_q <= ~bclk_q;
      if (fall) begin
        cnt      <= nxt;
        act_prev <= s_act;
        first_q  <= t_1st;
        sdout    <= t_bit;
        tx_take  <= start;
        if (start) hold <= tx_data;
      end
      if (rise && r_in) begin
        acc <= acc_n;
        if (r_last) begin
          rx_data  <= acc_n;
          rx_valid <= 1'b1;
        end
      end
    end

  assign bclk_o    = cfg_master & bclk_q;
  assign wclk_o    = cfg_master & (first_q ? cfg_pol : ~cfg_pol);
  assign clk_drive = cfg_master;

  AST_RESET_LINE_LOW: assert property (@(posedge clk) !rst_n |-> (sdout == 1'b0)); // R1
  AST_DATA_STILL_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $rose(bclk_o)) |-> $stable(sdout)); // R4
  AST_WCLK_STILL_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $rose(bclk_o)) |-> $stable(wclk_o)); // R4
  AST_TAKE_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && tx_take) |-> (wclk_o == cfg_pol)); // R8
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
endmodule

// File: tb/sim_audio_serial_port.sv
module sim_audio_serial_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, mclk_en = 1'b0;
  logic cfg_master = 1'b1, cfg_ratio64 = 1'b0, cfg_fsync = 1'b0, cfg_pol = 1'b0;
  logic cfg_delay1 = 1'b0, cfg_lsb = 1'b0;
  logic bclk_in = 1'b0, wclk_in = 1'b0, sdin = 1'b0;
  logic bclk_o, wclk_o, clk_drive, sdout, tx_take, rx_valid;
  logic [15:0] tx_data = '0;
  logic [15:0] rx_data;

  int total = 0, bad = 0, wd = 0;
  int nv, nt, fr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .cfg_master(cfg_master),
    .cfg_ratio64(cfg_ratio64), .cfg_fsync(cfg_fsync), .cfg_pol(cfg_pol),
    .cfg_delay1(cfg_delay1), .cfg_lsb(cfg_lsb), .bclk_in(bclk_in),
    .wclk_in(wclk_in), .sdin(sdin), .bclk_o(bclk_o), .wclk_o(wclk_o),
    .clk_drive(clk_drive), .sdout(sdout), .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid));

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] txw(input int n);
    return 16'hA5C3 ^ 16'(n * 16'h1357);
  endfunction
  function automatic logic [15:0] rxw(input int n);
    return 16'h3C96 + 16'(n * 16'h0F1D);
  endfunction
  function automatic logic exp_w(input int pos, input int f, input bit fs, input bit pol);
    bit first = fs ? (pos == 0) : (pos < f / 2);
    return first ? pol : !pol;
  endfunction
  function automatic logic exp_d(input int frm, input int pos, input bit d1, input bit lsb);
    int k = pos - int'(d1);
    logic [15:0] w = txw(frm);
    if (frm < 0 || k < 0 || k > 15) return 1'b0;
    return lsb ? w[k] : w[15 - k];
  endfunction
  function automatic logic drive_bit(input int frm, input int pos, input bit d1, input bit lsb);
    int k = pos - int'(d1);
    logic [15:0] w = rxw(frm);
    if (frm < 0 || k < 0 || k > 15) return 1'b1;
    return lsb ? w[k] : w[15 - k];
  endfunction

  task automatic mon();
    if (tx_take) begin
      nt++;
      tx_data = txw(nt);
    end
    if (rx_valid) begin
      chk(rx_data == rxw(nv), "R9", "slave rx word", rx_data, rxw(nv));
      nv++;
    end
  endtask

  task automatic run_master(input bit r64, input bit fs, input bit pol, input bit d1,
                            input bit lsb, input int div, input int nfr);
    int f = r64 ? 64 : 32;
    int pos, cyc, last_rise;
    logic pb, pw, ps;
    cfg_master = 1; cfg_ratio64 = r64; cfg_fsync = fs; cfg_pol = pol;
    cfg_delay1 = d1; cfg_lsb = lsb;
    rst_n = 0; mclk_en = 0; sdin = 0; tx_data = txw(0);
    repeat (3) @(negedge clk);
    chk(sdout == 0, "R1", "sdout in reset", sdout, 0);
    chk(bclk_o == 0, "R1", "bclk in reset", bclk_o, 0);
    chk(wclk_o == !pol, "R1", "wclk in reset", wclk_o, !pol);
    chk(rx_valid == 0, "R1", "rx_valid in reset", rx_valid, 0);
    chk(clk_drive == 1, "R2", "clk_drive master", clk_drive, 1);
    rst_n = 1;
    pos = f - 1; fr = -1; nv = 0; nt = 0; cyc = 0; last_rise = -1;
    pb = 0; pw = !pol; ps = 0;
    while (fr < nfr) begin
      mclk_en = ((cyc % div) == 0);
      @(negedge clk);
      cyc++;
      if (!pb && bclk_o) begin
        if (last_rise >= 0)
          chk(cyc - last_rise == 2 * div, "R2", "bit period", cyc - last_rise, 2 * div);
        last_rise = cyc;
        chk(wclk_o == exp_w(pos, f, fs, pol), "R3", "word clock", wclk_o, exp_w(pos, f, fs, pol));
        chk(sdout == exp_d(fr, pos, d1, lsb), "R5", "data bit (R6 R7)", sdout, exp_d(fr, pos, d1, lsb));
        chk(wclk_o == pw && sdout == ps, "R4", "change at rise", {wclk_o, sdout}, {pw, ps});
      end else if (pb && !bclk_o) begin
        pos = (pos + 1) % f;
        if (pos == 0) fr++;
        sdin = drive_bit(fr, pos, d1, lsb);
      end else begin
        chk(wclk_o == pw && sdout == ps, "R4", "change off edge", {wclk_o, sdout}, {pw, ps});
      end
      if (tx_take) begin
        chk(pos == 0 && !bclk_o, "R8", "take position", pos, 0);
        nt++;
        tx_data = txw(fr + 1);
      end
      if (rx_valid) begin
        chk(rx_data == rxw(nv), "R9", "master rx word (R7)", rx_data, rxw(nv));
        nv++;
      end
      pb = bclk_o; pw = wclk_o; ps = sdout;
    end
    mclk_en = 0;
    chk(nv == nfr, "R9", "rx word count", nv, nfr);
    chk(nt == nfr + 1, "R8", "take count", nt, nfr + 1);
  endtask

  task automatic run_slave(input int f, input bit fs, input bit pol, input bit d1,
                           input bit lsb, input int h, input int nfr);
    int pos;
    cfg_master = 0; cfg_ratio64 = 0; cfg_fsync = fs; cfg_pol = pol;
    cfg_delay1 = d1; cfg_lsb = lsb;
    rst_n = 0; mclk_en = 0; bclk_in = 0; wclk_in = !pol; sdin = 0; tx_data = txw(0);
    repeat (3) @(negedge clk);
    chk(sdout == 0, "R1", "slave sdout in reset", sdout, 0);
    chk(bclk_o == 0 && wclk_o == 0 && clk_drive == 0, "R10", "slave clocks undriven",
        {bclk_o, wclk_o, clk_drive}, 0);
    rst_n = 1;
    pos = f - 3; fr = -1; nv = 0; nt = 0;
    forever begin
      bclk_in = 0;
      wclk_in = exp_w(pos, f, fs, pol);
      sdin = drive_bit(fr, pos, d1, lsb);
      repeat (h) begin @(negedge clk); mon(); end
      chk(sdout == exp_d(fr, pos, d1, lsb), "R10", "slave data bit (R5 R6 R7)",
          sdout, exp_d(fr, pos, d1, lsb));
      bclk_in = 1;
      repeat (h) begin @(negedge clk); mon(); end
      pos++;
      if (pos == f) begin
        pos = 0;
        fr++;
        if (fr == nfr) break;
      end
    end
    chk(nv == nfr, "R10", "slave rx count", nv, nfr);
    chk(nt == nfr, "R8", "slave take count", nt, nfr);
    chk(bclk_o == 0 && wclk_o == 0, "R10", "slave outputs low", {bclk_o, wclk_o}, 0);
  endtask

  initial begin
    run_master(0, 0, 0, 1, 0, 1, 3);
    run_master(1, 0, 1, 0, 0, 2, 3);
    run_master(0, 1, 1, 0, 1, 1, 3);
    run_master(1, 1, 0, 1, 1, 3, 2);
    run_master(0, 0, 1, 1, 1, 2, 2);
    run_slave(128, 0, 0, 1, 0, 5, 2);
    run_slave(48, 1, 1, 0, 1, 4, 3);
    run_slave(32, 0, 1, 0, 0, 6, 2);
    run_slave(64, 1, 0, 1, 1, 5, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule